// File: doc/BRIEF.md
# Channel-aware audio sample FIFO

This block holds audio samples for one transmit direction. The CPU register port writes samples into it, and the serializer drains them one word at a time. The storage is a word RAM of `256 << SIZE_CODE` entries. The usable part of that RAM depends on the active channel count. The count is rounded up to the next power of two, and the per-channel depth is the RAM size divided by that rounded count. So three channels get the same per-channel depth as four, and five to seven channels get the same depth as eight.

Software sees two registers. The control register requests a flush and enables the half-full interrupt. The status register reports the fill level in whole frames (samples per channel) and carries two sticky error flags, one for writes dropped on a full FIFO and one for drains of an empty FIFO.

A two-state sequencer manages the flush:
- **ST_RUN** is the normal state, in which pushes and drains are accepted. Its transition **FLUSH_REQ** is taken on a control write with bit 0 set, and leads to ST_FLUSH.
- **ST_FLUSH** lasts one cycle. It resets the pointers and counters and ignores the data ports. Its transition **FLUSH_DONE** always returns to ST_RUN.

Top module: `pcm_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty. Both status flags and the level field are 0, the control register reads 0 and `half_irq` is low.
- R2: With T = 256 << SIZE_CODE, a channel count c in 1..MAX_CH gives a per-channel depth D = T >> s, where s is the smallest value with 2^s >= c. The capacity in words is D*c.
- R3: A push when the FIFO holds fewer than D*c words stores the word. A push when it holds D*c words drops the word and sets the overrun flag, which is status bit 4.
- R4: Drained words come out in write order. A drain accepted on the edge that samples `rd_req` presents the word on `rd_data` with `rd_valid` high in the following cycle.
- R5: A drain request on an empty FIFO returns no data (`rd_valid` stays low) and sets the underrun flag, which is status bit 0.
- R6: Status bits [16:8] hold floor(words/c), saturated at 511.
- R7: The error flags are sticky. A status write clears each flag whose written bit (4 or 0) is 0, so writing zero clears both. A new error in the same cycle wins over the clear. A flush leaves both flags unchanged.
- R8: A control write with bit 0 set starts a flush. For the next cycle control bit 0 reads 1 and pushes and drains are ignored. After that the FIFO is empty and bit 0 reads 0.
- R9: Control bit 20 is stored from every control write and reads back. When it is set, `half_irq` is high exactly while the word count is at most floor(D*c/2). When it is clear, `half_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_cnt | input | CH_W | Active channel count, 1..MAX_CH |
| wd_valid | input | 1 | Push a sample this cycle |
| wd_data | input | DW | Sample to push |
| rd_req | input | 1 | Drain request from the serializer |
| rd_data | output | DW | Drained sample |
| rd_valid | output | 1 | `rd_data` holds a drained sample |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data (bit 0 flush, bit 20 half-full interrupt enable) |
| ctrl_rdata | output | 32 | Control register readback |
| st_we | input | 1 | Status register write strobe |
| st_wdata | input | 32 | Status write data (a 0 in bit 4 or bit 0 clears that flag) |
| st_rdata | output | 32 | Status: level [16:8], overrun [4], underrun [0] |
| half_irq | output | 1 | Half-full transmit interrupt |

## Verification
The assertions assume that `chan_cnt` stays within 1..MAX_CH. They also assume that it changes only while the FIFO is empty or just before a flush, because the frame tally and the capacity check both use the current count. The stimulus respects this: it sets each channel count first and then issues a flush before any sample moves. It then fills and drains the FIFO one operation at a time. This keeps the bench's word count exact at every sampling point.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } fifo_state_e;

    localparam int CTRL_FLUSH_BIT = 0;
    localparam int CTRL_HALF_BIT  = 20;
    localparam int STAT_UND_BIT   = 0;
    localparam int STAT_OVR_BIT   = 4;
    localparam int STAT_LVL_LSB   = 8;
    localparam int STAT_LVL_W     = 9;

    // smallest s with (1 << s) >= ch, for ch up to 256
    function automatic int ch_shift(input int ch);
        int s;
        s = 0;
        for (int i = 0; i < 8; i++) begin
            if ((1 << s) < ch) s = s + 1;
        end
        return s;
    endfunction

endpackage

// File: rtl/pcm_fifo_capacity.sv
module pcm_fifo_capacity
    import pcm_fifo_pkg::*;
#(
    parameter int TOTAL  = 256,
    parameter int MAX_CH = 8,
    parameter int CH_W   = 4,
    parameter int OCC_W  = 9
) (
    input  logic [CH_W-1:0]  chan,
    output logic [OCC_W-1:0] cap_words,
    output logic [OCC_W-1:0] half_words
);

    logic [OCC_W-1:0] cap_tbl [MAX_CH+1];

    for (genvar g = 0; g <= MAX_CH; g++) begin : g_cap
        localparam int EFF = (g == 0) ? 1 : g;
        localparam int CAP = (TOTAL >> ch_shift(EFF)) * EFF;
        assign cap_tbl[g] = OCC_W'(CAP);
    end

    always_comb begin
        if (chan <= CH_W'(MAX_CH)) cap_words = cap_tbl[chan];
        else                       cap_words = cap_tbl[1];
    end

    assign half_words = cap_words >> 1;

endmodule

// File: rtl/pcm_fifo_ram.sv
module pcm_fifo_ram #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= pop;
            if (pop) rdata <= mem[rp_q];
            if (flush) begin
                wp_q <= '0;
                rp_q <= '0;
            end else begin
                if (push) wp_q <= wp_q + AW'(1);
                if (pop)  rp_q <= rp_q + AW'(1);
            end
        end
    end

endmodule

// File: rtl/pcm_fifo_tally.sv
module pcm_fifo_tally #(
    parameter int CH_W  = 4,
    parameter int OCC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [CH_W-1:0]  chan,
    output logic [OCC_W-1:0] occ,
    output logic [OCC_W-1:0] frames
);

    logic [CH_W-1:0] slot_q;
    logic [CH_W-1:0] last_slot;

    assign last_slot = chan - CH_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ    <= '0;
            frames <= '0;
            slot_q <= '0;
        end else if (flush) begin
            occ    <= '0;
            frames <= '0;
            slot_q <= '0;
        end else if (push && !pop) begin
            occ <= occ + OCC_W'(1);
            if (slot_q == last_slot) begin
                slot_q <= '0;
                frames <= frames + OCC_W'(1);
            end else begin
                slot_q <= slot_q + CH_W'(1);
            end
        end else if (pop && !push) begin
            occ <= occ - OCC_W'(1);
            if (slot_q == '0) begin
                slot_q <= last_slot;
                frames <= frames - OCC_W'(1);
            end else begin
                slot_q <= slot_q - CH_W'(1);
            end
        end
    end

endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo
    import pcm_fifo_pkg::*;
#(
    parameter int SIZE_CODE = 0,
    parameter int DW        = 24,
    parameter int MAX_CH    = 8,
    localparam int CH_W     = $clog2(MAX_CH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] chan_cnt,
    input  logic            wd_valid,
    input  logic [DW-1:0]   wd_data,
    input  logic            rd_req,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    input  logic            ctrl_we,
    input  logic [31:0]     ctrl_wdata,
    output logic [31:0]     ctrl_rdata,
    input  logic            st_we,
    input  logic [31:0]     st_wdata,
    output logic [31:0]     st_rdata,
    output logic            half_irq
);

    localparam int TOTAL   = 256 << SIZE_CODE;
    localparam int AW      = $clog2(TOTAL);
    localparam int OCC_W   = AW + 1;
    localparam int LVL_MAX = (1 << STAT_LVL_W) - 1;

    fifo_state_e state_q, state_d;

    logic [OCC_W-1:0] occ, frames, cap_words, half_words;
    logic [STAT_LVL_W-1:0] lvl_field;
    logic running, flushing, flush_req;
    logic push_ok, push_drop, pop_ok, pop_miss;
    logic ovr_q, und_q, half_sel_q;

    assign flush_req = ctrl_we && ctrl_wdata[CTRL_FLUSH_BIT];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (flush_req) state_d = ST_FLUSH;  // FLUSH_REQ
            ST_FLUSH: state_d = ST_RUN;                   // FLUSH_DONE
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        running  = 1'b0;
        flushing = 1'b0;
        unique case (state_q)
            ST_RUN:   running  = 1'b1;
            ST_FLUSH: flushing = 1'b1;
            default:  running  = 1'b1;
        endcase
    end

    assign push_ok   = running && wd_valid && (occ <  cap_words);
    assign push_drop = running && wd_valid && (occ >= cap_words);
    assign pop_ok    = running && rd_req   && (occ != '0);
    assign pop_miss  = running && rd_req   && (occ == '0);

    pcm_fifo_capacity #(
        .TOTAL(TOTAL), .MAX_CH(MAX_CH), .CH_W(CH_W), .OCC_W(OCC_W)
    ) u_cap (
        .chan(chan_cnt), .cap_words(cap_words), .half_words(half_words)
    );

    pcm_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk(clk), .rst_n(rst_n), .flush(flushing),
        .push(push_ok), .wdata(wd_data),
        .pop(pop_ok), .rdata(rd_data), .rvalid(rd_valid)
    );

    pcm_fifo_tally #(.CH_W(CH_W), .OCC_W(OCC_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .flush(flushing),
        .push(push_ok), .pop(pop_ok), .chan(chan_cnt),
        .occ(occ), .frames(frames)
    );

    // sticky flags and control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q      <= 1'b0;
            und_q      <= 1'b0;
            half_sel_q <= 1'b0;
        end else begin
            if (ctrl_we) half_sel_q <= ctrl_wdata[CTRL_HALF_BIT];
            if (push_drop)
                ovr_q <= 1'b1;
            else if (st_we && !st_wdata[STAT_OVR_BIT])
                ovr_q <= 1'b0;
            if (pop_miss)
                und_q <= 1'b1;
            else if (st_we && !st_wdata[STAT_UND_BIT])
                und_q <= 1'b0;
        end
    end

    if (OCC_W > STAT_LVL_W) begin : g_lvl_sat
        assign lvl_field = (frames > OCC_W'(LVL_MAX)) ? STAT_LVL_W'(LVL_MAX)
                                                      : frames[STAT_LVL_W-1:0];
    end else begin : g_lvl_ext
        assign lvl_field = STAT_LVL_W'(frames);
    end

    assign st_rdata   = {15'd0, lvl_field, 3'd0, ovr_q, 3'd0, und_q};
    assign ctrl_rdata = {11'd0, half_sel_q, 19'd0, flushing};
    assign half_irq   = half_sel_q && (occ <= half_words);

endmodule

// File: rtl/pcm_sample_fifo_chk.sv
module pcm_sample_fifo_chk #(
    parameter int OCC_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             flushing,
    input logic             wd_valid,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [OCC_W-1:0] occ,
    input logic [OCC_W-1:0] cap_words,
    input logic             ovr_q,
    input logic             und_q,
    input logic             st_we,
    input logic             st_ovr_bit,
    input logic             half_sel_q,
    input logic             half_irq
);

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= cap_words);  // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        running && wd_valid && !rd_req && (occ == cap_words)
        |=> ovr_q && (occ == $past(occ)));  // R3

    AST_DRAIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));  // R4

    AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        running && rd_req && (occ == '0) |=> und_q && !rd_valid);  // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && !(st_we && !st_ovr_bit) |=> ovr_q);  // R7

    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> running && (occ == '0));  // R8

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !half_sel_q |-> !half_irq);  // R9

endmodule

bind pcm_sample_fifo pcm_sample_fifo_chk #(.OCC_W(OCC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .flushing(flushing),
    .wd_valid(wd_valid), .rd_req(rd_req), .rd_valid(rd_valid),
    .occ(occ), .cap_words(cap_words), .ovr_q(ovr_q), .und_q(und_q),
    .st_we(st_we), .st_ovr_bit(st_wdata[4]),
    .half_sel_q(half_sel_q), .half_irq(half_irq)
);

// File: tb/pcm_sample_fifo_tb.sv
module pcm_sample_fifo_tb;

    localparam int DW     = 24;
    localparam int MAX_CH = 8;
    localparam int CH_W   = 4;
    localparam int TOTAL  = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CH_W-1:0] chan_cnt = CH_W'(1);
    logic            wd_valid = 1'b0;
    logic [DW-1:0]   wd_data = '0;
    logic            rd_req = 1'b0;
    logic [DW-1:0]   rd_data;
    logic            rd_valid;
    logic            ctrl_we = 1'b0;
    logic [31:0]     ctrl_wdata = '0;
    logic [31:0]     ctrl_rdata;
    logic            st_we = 1'b0;
    logic [31:0]     st_wdata = '0;
    logic [31:0]     st_rdata;
    logic            half_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcm_sample_fifo #(.SIZE_CODE(0), .DW(DW), .MAX_CH(MAX_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt),
        .wd_valid(wd_valid), .wd_data(wd_data),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .half_irq(half_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge clk); wd_valid = 1'b1; wd_data = d;
        @(negedge clk); wd_valid = 1'b0;
    endtask

    task automatic pop(output bit v, output int d);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        v = rd_valid; d = int'(rd_data);
    endtask

    task automatic ctrl_write(input logic [31:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic st_write(input logic [31:0] v);
        @(negedge clk); st_we = 1'b1; st_wdata = v;
        @(negedge clk); st_we = 1'b0;
    endtask

    function automatic int exp_cap(input int ch);
        int s = 0;
        while ((1 << s) < ch) s++;
        return (TOTAL >> s) * ch;
    endfunction

    function automatic int pattern(input int ch, input int i);
        return ((ch << 16) | i) & 32'hFFFFFF;
    endfunction

    function automatic int lvl_of(input logic [31:0] st);
        return int'(st[16:8]);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        bit v;
        int d;
        int cap;
        int occ;

        repeat (3) @(negedge clk);
        check(st_rdata == 32'd0, "R1 status", int'(st_rdata), 0);
        check(ctrl_rdata == 32'd0, "R1 control", int'(ctrl_rdata), 0);
        check(half_irq == 1'b0, "R1 irq", int'(half_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int ch = 1; ch <= MAX_CH; ch++) begin
            chan_cnt = CH_W'(ch);
            ctrl_write(32'h0010_0001);
            check(ctrl_rdata[0] == 1'b1, "R8 flush busy", int'(ctrl_rdata[0]), 1);
            @(negedge clk);
            check(ctrl_rdata[0] == 1'b0, "R8 flush done", int'(ctrl_rdata[0]), 0);
            check(ctrl_rdata[20] == 1'b1, "R9 half select readback", int'(ctrl_rdata[20]), 1);
            st_write(32'h0);
            check(st_rdata == 32'd0, "R8 empty after flush", int'(st_rdata), 0);
            cap = exp_cap(ch);
            occ = 0;
            check(half_irq == 1'b1, "R9 irq when empty", int'(half_irq), 1);

            for (int i = 0; i < cap; i++) begin
                push(DW'(pattern(ch, i)));
                occ++;
                check(lvl_of(st_rdata) == occ / ch, "R6 level on fill", lvl_of(st_rdata), occ / ch);
                check(half_irq == (occ <= cap / 2), "R9 irq on fill", int'(half_irq), int'(occ <= cap / 2));
            end
            check(st_rdata[4] == 1'b0, "R3 no overrun up to capacity", int'(st_rdata[4]), 0);
            push(DW'(24'hABCDEF));
            check(st_rdata[4] == 1'b1, "R3 overrun at capacity", int'(st_rdata[4]), 1);
            check(lvl_of(st_rdata) == cap / ch, "R2 capacity frames", lvl_of(st_rdata), cap / ch);

            for (int i = 0; i < cap; i++) begin
                pop(v, d);
                occ--;
                check(v && d == pattern(ch, i), "R4 drain order", d, pattern(ch, i));
                check(lvl_of(st_rdata) == occ / ch, "R6 level on drain", lvl_of(st_rdata), occ / ch);
            end
            pop(v, d);
            check(v == 1'b0, "R5 no data when empty", int'(v), 0);
            check(st_rdata[0] == 1'b1, "R5 underrun flag", int'(st_rdata[0]), 1);

            st_write(32'h10);
            check(st_rdata[4] == 1'b1 && st_rdata[0] == 1'b0, "R7 selective clear",
                  int'(st_rdata[4:0]), 16);
            st_write(32'h0);
            check(st_rdata[4:0] == 5'd0, "R7 clear both", int'(st_rdata[4:0]), 0);
        end

        // flush ignores a push in its busy cycle; flags survive the flush
        chan_cnt = CH_W'(2);
        ctrl_write(32'h1);
        @(negedge clk);
        for (int i = 0; i < 3; i++) push(DW'(i + 7));
        pop(v, d);
        pop(v, d);
        pop(v, d);
        pop(v, d);
        check(st_rdata[0] == 1'b1, "R5 underrun set before flush", int'(st_rdata[0]), 1);
        push(DW'(5));
        push(DW'(6));
        push(DW'(7));
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 32'h1;
        @(negedge clk); ctrl_we = 1'b0; wd_valid = 1'b1; wd_data = DW'(99);
        check(ctrl_rdata[0] == 1'b1, "R8 busy cycle", int'(ctrl_rdata[0]), 1);
        @(negedge clk); wd_valid = 1'b0;
        check(lvl_of(st_rdata) == 0, "R8 push ignored during flush", lvl_of(st_rdata), 0);
        check(st_rdata[0] == 1'b1, "R7 flag kept across flush", int'(st_rdata[0]), 1);
        check(ctrl_rdata[20] == 1'b0 && half_irq == 1'b0, "R9 irq off when deselected",
              int'(half_irq), 0);
        st_write(32'h0);
        pop(v, d);
        check(v == 1'b0 && st_rdata[0] == 1'b1, "R8 storage empty after flush", int'(v), 0);

        done = 1'b1;
        summary();
    end

endmodule